// File: doc/BRIEF.md
# Serial-In Latched Output Driver Logic

This block is the digital core of a multi-channel serial-to-parallel output driver. A chain of register stages takes one serial bit per shift pulse. A bank of hold stages copies the chain while a strobe is high and keeps its contents while the strobe is low. An active-low enable then gates the per-channel driver-on outputs. The last stage of the chain is brought out as a serial output, so several blocks can be chained to drive more lines from one serial stream.

The block runs in a single system clock domain. A shift pulse is a cycle with `shift_en` high: on that rising edge the first stage takes `ser_in` and every other stage takes the value of the stage before it. The number of stages is a parameter, with a default of 8. A second parameter picks how the hold bank is built. The default is a strobe-qualified register, which is synthesizable without latches. The other choice is a level-transparent latch. The block has no state machine: its only sequencing is the shift chain itself.

Top module: `serial_latched_driver`

## Requirements
- R1: The reset `rst` is synchronous and active high. At the clock edge after `rst` is sampled high, every chain stage and every hold stage is 0, so `drv_on` is all zero and `ser_out` is 0.
- R2: On a rising edge with `shift_en` high, stage 0 takes `ser_in` and stage k takes stage k-1. On an edge with `shift_en` low, the chain keeps its value.
- R3: `ser_out` equals the last chain stage. When two blocks are chained (the first block's `ser_out` drives the second block's `ser_in`), a 16-bit word sent MSB first lands with word bit p on combined channel p. Channels 0..7 are on the first block and channels 8..15 are on the second.
- R4: On an edge with `strobe` high, the hold bank takes the chain contents that were present before that edge. On an edge with `strobe` low, the hold bank keeps its value, whatever shifting happens.
- R5: While `enable_n` is 1, every `drv_on` bit is 0. Toggling `enable_n` changes neither the chain (seen at `ser_out`) nor the hold bank (seen at `drv_on` once `enable_n` is 0 again).
- R6: While `enable_n` is 0, `drv_on[k]` is 1 exactly when hold stage k holds 1.
- R7: With `strobe` held high, the hold bank follows the chain one edge behind. After n bits of a byte are sent MSB first into a cleared chain and one idle cycle follows, `drv_on` equals the byte shifted right by 8-n.
- R8: A byte sent MSB first and then strobed appears on `drv_on` with byte bit k on channel k. Channel 0 holds the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit entering stage 0 |
| shift_en | input | 1 | High for one cycle per shift pulse |
| strobe | input | 1 | High to let the hold bank copy the chain |
| enable_n | input | 1 | Active-low output enable; high forces all outputs off |
| ser_out | output | 1 | Last chain stage, for chaining blocks |
| drv_on | output | STAGES | Per-channel driver-on request |

## Verification
The assertions assume that `rst` is asserted for at least one edge before the first check that depends on it, and that `shift_en`, `strobe` and `enable_n` are stable around each rising edge. The bench meets both by driving every input on the falling edge and by starting each scenario with a reset. The assertions also assume that a frame is strobed only after its last shift pulse. The bench drives `shift_en` low before it raises `strobe`, except in the transparent-follow scenario, where the strobe is deliberately held high throughout.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;
    typedef enum logic {
        HOLD_CLOCKED     = 1'b0,
        HOLD_TRANSPARENT = 1'b1
    } hold_mode_e;

    localparam int DEFAULT_STAGES = 8;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int STAGES = sipo_drv_pkg::DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic [STAGES-1:0] stage_q
);
    localparam int LAST = STAGES - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (shift_en) begin
            stage_q <= {stage_q[LAST-1:0], ser_in};
        end
    end

    // R1: chain cleared one edge after reset
    a_r1_chain_cleared: assert property (@(posedge clk)
        rst |=> (stage_q == '0));

    // R2: no shift pulse, no movement
    a_r2_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stage_q));

    // R3: the last stage is fed from its neighbour
    a_r3_last_fed: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (stage_q[LAST] == $past(stage_q[LAST-1])));
endmodule

// File: rtl/sipo_hold_bank.sv
module sipo_hold_bank #(
    parameter int                       STAGES    = sipo_drv_pkg::DEFAULT_STAGES,
    parameter sipo_drv_pkg::hold_mode_e HOLD_MODE = sipo_drv_pkg::HOLD_CLOCKED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [STAGES-1:0] chain_d,
    output logic [STAGES-1:0] hold_q
);
    generate
        if (HOLD_MODE == sipo_drv_pkg::HOLD_CLOCKED) begin : g_clocked
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= '0;
                end else if (strobe) begin
                    hold_q <= chain_d;
                end
            end

            // R4: strobe low keeps the hold bank
            a_r4_keep_when_low: assert property (@(posedge clk) disable iff (rst)
                !strobe |=> $stable(hold_q));

            // R1: hold bank cleared one edge after reset
            a_r1_hold_cleared: assert property (@(posedge clk)
                rst |=> (hold_q == '0));
        end else begin : g_transparent
            always_latch begin
                if (rst) begin
                    hold_q = '0;
                end else if (strobe) begin
                    hold_q = chain_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
    parameter int STAGES = sipo_drv_pkg::DEFAULT_STAGES
) (
    input  logic              enable_n,
    input  logic [STAGES-1:0] hold_d,
    output logic [STAGES-1:0] drv_on
);
    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_ch
            assign drv_on[k] = hold_d[k] & ~enable_n;
        end
    endgenerate
endmodule

// File: rtl/serial_latched_driver.sv
module serial_latched_driver #(
    parameter int                       STAGES    = sipo_drv_pkg::DEFAULT_STAGES,
    parameter sipo_drv_pkg::hold_mode_e HOLD_MODE = sipo_drv_pkg::HOLD_CLOCKED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              shift_en,
    input  logic              strobe,
    input  logic              enable_n,
    output logic              ser_out,
    output logic [STAGES-1:0] drv_on
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] hold_q;

    sipo_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .stage_q  (chain_q)
    );

    sipo_hold_bank #(.STAGES(STAGES), .HOLD_MODE(HOLD_MODE)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .chain_d (chain_q),
        .hold_q  (hold_q)
    );

    sipo_out_gate #(.STAGES(STAGES)) u_gate (
        .enable_n (enable_n),
        .hold_d   (hold_q),
        .drv_on   (drv_on)
    );

    assign ser_out = chain_q[STAGES-1];

    // R5: disabled outputs are all off
    a_r5_blank_when_disabled: assert property (@(posedge clk) disable iff (rst)
        enable_n |-> (drv_on == '0));

    // R6: an active output always has a held 1 behind it
    a_r6_on_needs_hold: assert property (@(posedge clk) disable iff (rst)
        ((drv_on & ~hold_q) == '0));
endmodule

// File: tb/serial_latched_driver_tb_top.sv
`timescale 1ns/1ps
module serial_latched_driver_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic ser_in, shift_en, strobe, enable_n;
    logic ser_out;
    logic [7:0] drv_on;

    logic c_ser_in, c_shift_en, c_strobe, c_enable_n;
    logic a_ser_out, b_ser_out;
    logic [7:0] a_drv_on, b_drv_on;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    serial_latched_driver #(.STAGES(8)) dut_i (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en),
        .strobe(strobe), .enable_n(enable_n), .ser_out(ser_out), .drv_on(drv_on)
    );

    serial_latched_driver #(.STAGES(8)) casc_a (
        .clk(clk), .rst(rst), .ser_in(c_ser_in), .shift_en(c_shift_en),
        .strobe(c_strobe), .enable_n(c_enable_n), .ser_out(a_ser_out), .drv_on(a_drv_on)
    );

    serial_latched_driver #(.STAGES(8)) casc_b (
        .clk(clk), .rst(rst), .ser_in(a_ser_out), .shift_en(c_shift_en),
        .strobe(c_strobe), .enable_n(c_enable_n), .ser_out(b_ser_out), .drv_on(b_drv_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk);
            ser_in   = v[i];
            shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 reset drv_on", 32'(drv_on), 32'h0);
        chk("R1 reset ser_out", 32'(ser_out), 32'h0);
    endtask

    task automatic t_byte_load();
        enable_n = 1'b0;
        send_bits(8'hA5, 8);
        pulse_strobe();
        chk("R8 byte order on drv_on", 32'(drv_on), 32'hA5);
        chk("R6 enabled follows hold", 32'(drv_on), 32'hA5);
        chk("R3 ser_out first bit", 32'(ser_out), 32'h1);
    endtask

    task automatic t_hold_keeps();
        send_bits(8'h5A, 8);
        chk("R4 strobe low keeps", 32'(drv_on), 32'hA5);
        chk("R3 ser_out new first bit", 32'(ser_out), 32'h0);
        pulse_strobe();
        chk("R4 strobe high loads", 32'(drv_on), 32'h5A);
    endtask

    task automatic t_partial_shift();
        do_reset();
        send_bits(8'hC0, 3);
        @(negedge clk);
        chk("R2 no pulse no shift", 32'(ser_out), 32'h0);
        pulse_strobe();
        chk("R2 three bits shifted", 32'(drv_on), 32'h6);
    endtask

    task automatic t_transparent();
        do_reset();
        enable_n = 1'b0;
        strobe   = 1'b1;
        send_bits(8'hC3, 4);
        @(negedge clk);
        chk("R7 follow after 4 bits", 32'(drv_on), 32'h0C);
        for (int i = 3; i >= 0; i--) begin
            ser_in   = i[0] ? 1'b0 : 1'b0;
            ser_in   = (8'hC3 >> i) & 8'h1;
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
        @(negedge clk);
        chk("R7 follow after 8 bits", 32'(drv_on), 32'hC3);
        strobe = 1'b0;
    endtask

    task automatic t_enable_gating();
        enable_n = 1'b1;
        @(negedge clk);
        chk("R5 disabled all off", 32'(drv_on), 32'h0);
        for (int i = 7; i >= 0; i--) begin
            ser_in   = (8'h81 >> i) & 8'h1;
            shift_en = 1'b1;
            enable_n = i[0];
            @(negedge clk);
        end
        shift_en = 1'b0;
        enable_n = 1'b1;
        @(negedge clk);
        chk("R5 disabled still off", 32'(drv_on), 32'h0);
        chk("R5 ser_out unaffected", 32'(ser_out), 32'h1);
        enable_n = 1'b0;
        @(negedge clk);
        chk("R5 hold kept across enable", 32'(drv_on), 32'hC3);
        pulse_strobe();
        chk("R5 chain kept across enable", 32'(drv_on), 32'h81);
    endtask

    task automatic t_cascade();
        logic [15:0] w;
        w = 16'hB36D;
        c_enable_n = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            c_ser_in   = w[i];
            c_shift_en = 1'b1;
        end
        @(negedge clk);
        c_shift_en = 1'b0;
        c_strobe   = 1'b1;
        @(negedge clk);
        c_strobe = 1'b0;
        chk("R3 cascade 16-bit frame", 32'({b_drv_on, a_drv_on}), 32'(w));
        chk("R3 cascade far ser_out", 32'(b_ser_out), 32'(w[15]));
    endtask

    task automatic t_reset_after_data();
        do_reset();
        chk("R1 reset clears loaded drv_on", 32'(drv_on), 32'h0);
        chk("R1 reset clears cascade", 32'({b_drv_on, a_drv_on}), 32'h0);
    endtask

    initial begin
        rst = 1'b1;
        ser_in = 1'b0; shift_en = 1'b0; strobe = 1'b0; enable_n = 1'b0;
        c_ser_in = 1'b0; c_shift_en = 1'b0; c_strobe = 1'b0; c_enable_n = 1'b0;
        t_reset_state();
        t_byte_load();
        t_hold_keeps();
        t_partial_shift();
        t_transparent();
        t_enable_gating();
        t_cascade();
        t_reset_after_data();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule